// File: doc/BRIEF.md
# Self-Refresh Exit Command Timing Gate

This block sits beside the command scheduler of one DRAM channel and tells it, cycle by cycle, which classes of command may be issued. A mode-register write closes the gate for every command for a short programmable window. Leaving self-refresh closes it for much longer. All commands wait for the refresh-cycle time plus a small offset. Commands that move data also wait for the DLL to relock. Non-data and data commands further wait for a long ZQ calibration, which the block requests and then times.

The scheduler reads three permits: any command, non-data commands, and read/write commands. It pulses `sr_exit_i` on the cycle it takes the channel out of self-refresh and pulses `mrs_issued_i` when it sends a mode-register write. It issues the calibration command when `zqcl_req_o` is high and reports it on `zqcl_issued_i`. All timing values are static configuration inputs counted in DCLK cycles.

A strobe is counted from the rising clock edge that samples it. A window of N cycles means the affected permit reads low for the N cycles after that edge and high from the cycle after.

Top module: `sr_exit_gate`

## Requirements
- R1: After an MRS strobe, `cmd_any_ok_o` is low for exactly 8 + `cfg_tmod_i` cycles, then high again.
- R2: `cfg_tmod_i` is a 4-bit unsigned offset: 0 gives the 8-cycle floor, 4 gives 12 cycles and 15 gives 23 cycles.
- R3: After a self-refresh exit strobe, `cmd_any_ok_o` is low for exactly `cfg_trfc_i` + (clamped offset) cycles.
- R4: The 4-bit offset `cfg_txs_ofs_i` is clamped to 3..11 before use: 0 acts as 3, 15 acts as 11, and values inside the range are used unchanged.
- R5: `cmd_rdwr_ok_o` stays low for at least the clamped DLL delay after an exit. The 12-bit `cfg_txsdll_i` is clamped to 128..1024, so 5 acts as 128, 2000 acts as 1024 and 300 stays 300.
- R6: `zqcl_req_o` rises one cycle after the exit delay of R3 has run out. It stays high until `zqcl_issued_i` is sampled high, and it drops on the next cycle. A `zqcl_issued_i` pulse while the request is low has no effect.
- R7: `cmd_nodata_ok_o` is high only once the exit delay has run out and `cfg_tzqoper_i` cycles (a 10-bit value, 0 allowed) have passed since the accepted calibration strobe. The request is high for one cycle after the exit delay ends, so when the strobe answers the request at once, the permit first reads high T + 2 + `cfg_tzqoper_i` cycles after the exit edge.
- R8: `cmd_rdwr_ok_o` needs everything `cmd_nodata_ok_o` needs and also the end of the DLL delay. It rises at whichever of the two ends later.
- R9: A new exit or MRS strobe that arrives while a window is running restarts that window from its full length. An exit during a pending or running calibration withdraws the request and restarts the whole exit sequence.
- R10: While reset is asserted, whether at start-up or in mid-sequence, all three permits are high and `zqcl_req_o` is low. Reset takes effect at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DCLK |
| rst_n | input | 1 | Reset, active low, asserted asynchronously and released on a clock edge |
| sr_exit_i | input | 1 | One-cycle strobe: channel leaves self-refresh |
| mrs_issued_i | input | 1 | One-cycle strobe: mode-register write sent |
| zqcl_issued_i | input | 1 | One-cycle strobe: ZQ long calibration command sent |
| cfg_trfc_i | input | 10 | Refresh-cycle time in cycles |
| cfg_txs_ofs_i | input | 4 | Exit offset added to the refresh-cycle time (clamped 3..11) |
| cfg_txsdll_i | input | 12 | DLL relock delay before data commands (clamped 128..1024) |
| cfg_tzqoper_i | input | 10 | Calibration duration in cycles |
| cfg_tmod_i | input | 4 | MRS offset above the 8-cycle floor |
| cmd_any_ok_o | output | 1 | Any command may issue |
| cmd_nodata_ok_o | output | 1 | Commands without data transfer may issue |
| cmd_rdwr_ok_o | output | 1 | Read and write commands may issue |
| zqcl_req_o | output | 1 | Request to issue the ZQ long calibration |

## Verification
The hardest state to reach from the ports is the handover of the calibration phase. The bench must answer the request on exactly the cycle it appears, or the timing of the permits shifts. A stray strobe before the request must also prove to have no effect. Each exit run therefore has the stimulus watch `zqcl_req_o` at every sample point and echo it onto `zqcl_issued_i` in the same cycle. This gives the fixed relation that R7 and R8 rely on. One run also drives the strobe on the first cycle after the exit and checks that every milestone stays where it was. A second exit fired partway through a sequence, and a reset asserted in mid-sequence, cover the restart paths.

// File: rtl/sr_gate_pkg.sv
package sr_gate_pkg;

  // Calibration phase of the exit sequence
  typedef enum logic [1:0] {
    ZQ_IDLE    = 2'd0,  // no calibration owed
    ZQ_WAIT_XS = 2'd1,  // exit delay still running
    ZQ_REQ     = 2'd2,  // asking the scheduler for the command
    ZQ_OPER    = 2'd3   // calibration in progress, being timed
  } zq_state_e;

  localparam int DEF_TRFC_W    = 10;
  localparam int DEF_OFS_W     = 4;
  localparam int DEF_DLL_W     = 12;
  localparam int DEF_ZQ_W      = 10;
  localparam int DEF_MOD_W     = 4;
  localparam int DEF_MOD_FLOOR = 8;
  localparam int DEF_OFS_MIN   = 3;
  localparam int DEF_OFS_MAX   = 11;
  localparam int DEF_DLL_MIN   = 128;
  localparam int DEF_DLL_MAX   = 1024;

endpackage

// File: rtl/sr_gate_cnt.sv
// Loadable down-counter; zero_o marks an expired window.
module sr_gate_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i | (cnt_q != '0);
    cnt_d  = load_i ? val_i : (cnt_q - W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sr_gate_zq.sv
// Sequencer for the post-exit long calibration.
module sr_gate_zq
  import sr_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic exit_i,
  input  logic xs_zero_i,
  input  logic zq_issued_i,
  input  logic oper_zero_i,
  output logic oper_load_o,
  output logic req_o,
  output logic zq_ok_o
);

  zq_state_e st_q;
  zq_state_e st_d;

  always_comb begin
    st_d        = st_q;
    oper_load_o = 1'b0;
    if (exit_i) begin
      st_d = ZQ_WAIT_XS;
    end else begin
      unique case (st_q)
        ZQ_IDLE:    st_d = ZQ_IDLE;
        ZQ_WAIT_XS: if (xs_zero_i) st_d = ZQ_REQ;
        ZQ_REQ: begin
          if (zq_issued_i) begin
            st_d        = ZQ_OPER;
            oper_load_o = 1'b1;
          end
        end
        ZQ_OPER:    if (oper_zero_i) st_d = ZQ_IDLE;
        default:    st_d = ZQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ZQ_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign req_o   = (st_q == ZQ_REQ);
  assign zq_ok_o = (st_q == ZQ_IDLE) | ((st_q == ZQ_OPER) & oper_zero_i);

endmodule

// File: rtl/sr_exit_gate.sv
// Command permits after self-refresh exit and mode-register writes.
module sr_exit_gate
  import sr_gate_pkg::*;
#(
  parameter int TRFC_W    = DEF_TRFC_W,
  parameter int OFS_W     = DEF_OFS_W,
  parameter int DLL_W     = DEF_DLL_W,
  parameter int ZQ_W      = DEF_ZQ_W,
  parameter int MOD_W     = DEF_MOD_W,
  parameter int MOD_FLOOR = DEF_MOD_FLOOR,
  parameter int OFS_MIN   = DEF_OFS_MIN,
  parameter int OFS_MAX   = DEF_OFS_MAX,
  parameter int DLL_MIN   = DEF_DLL_MIN,
  parameter int DLL_MAX   = DEF_DLL_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sr_exit_i,
  input  logic              mrs_issued_i,
  input  logic              zqcl_issued_i,
  input  logic [TRFC_W-1:0] cfg_trfc_i,
  input  logic [OFS_W-1:0]  cfg_txs_ofs_i,
  input  logic [DLL_W-1:0]  cfg_txsdll_i,
  input  logic [ZQ_W-1:0]   cfg_tzqoper_i,
  input  logic [MOD_W-1:0]  cfg_tmod_i,
  output logic              cmd_any_ok_o,
  output logic              cmd_nodata_ok_o,
  output logic              cmd_rdwr_ok_o,
  output logic              zqcl_req_o
);

  localparam int XS_W   = ((TRFC_W > OFS_W) ? TRFC_W : OFS_W) + 1;
  localparam int MODC_W = $clog2(MOD_FLOOR + (1 << MOD_W));

  localparam logic [OFS_W-1:0]  OFS_LO  = OFS_W'(OFS_MIN);
  localparam logic [OFS_W-1:0]  OFS_HI  = OFS_W'(OFS_MAX);
  localparam logic [DLL_W-1:0]  DLL_LO  = DLL_W'(DLL_MIN);
  localparam logic [DLL_W-1:0]  DLL_HI  = DLL_W'(DLL_MAX);
  localparam logic [MODC_W-1:0] MOD_BASE = MODC_W'(MOD_FLOOR);

  // Reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_q_n = rst_sync_q[1];

  // Clamped load values
  logic [OFS_W-1:0]  ofs_clamped;
  logic [DLL_W-1:0]  dll_clamped;
  logic [XS_W-1:0]   xs_load_val;
  logic [MODC_W-1:0] mod_load_val;

  always_comb begin
    if (cfg_txs_ofs_i < OFS_LO) begin
      ofs_clamped = OFS_LO;
    end else if (cfg_txs_ofs_i > OFS_HI) begin
      ofs_clamped = OFS_HI;
    end else begin
      ofs_clamped = cfg_txs_ofs_i;
    end

    if (cfg_txsdll_i < DLL_LO) begin
      dll_clamped = DLL_LO;
    end else if (cfg_txsdll_i > DLL_HI) begin
      dll_clamped = DLL_HI;
    end else begin
      dll_clamped = cfg_txsdll_i;
    end

    xs_load_val  = XS_W'(cfg_trfc_i) + XS_W'(ofs_clamped);
    mod_load_val = MOD_BASE + MODC_W'(cfg_tmod_i);
  end

  // Window counters
  logic mod_zero;
  logic xs_zero;
  logic dll_zero;
  logic oper_zero;
  logic oper_load;
  logic zq_ok;

  sr_gate_cnt #(.W(MODC_W)) u_mod_cnt (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .load_i (mrs_issued_i),
    .val_i  (mod_load_val),
    .zero_o (mod_zero)
  );

  sr_gate_cnt #(.W(XS_W)) u_xs_cnt (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .load_i (sr_exit_i),
    .val_i  (xs_load_val),
    .zero_o (xs_zero)
  );

  sr_gate_cnt #(.W(DLL_W)) u_dll_cnt (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .load_i (sr_exit_i),
    .val_i  (dll_clamped),
    .zero_o (dll_zero)
  );

  sr_gate_cnt #(.W(ZQ_W)) u_oper_cnt (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .load_i (oper_load),
    .val_i  (cfg_tzqoper_i),
    .zero_o (oper_zero)
  );

  sr_gate_zq u_zq (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .exit_i      (sr_exit_i),
    .xs_zero_i   (xs_zero),
    .zq_issued_i (zqcl_issued_i),
    .oper_zero_i (oper_zero),
    .oper_load_o (oper_load),
    .req_o       (zqcl_req_o),
    .zq_ok_o     (zq_ok)
  );

  // Permits
  always_comb begin
    cmd_any_ok_o    = mod_zero & xs_zero;
    cmd_nodata_ok_o = cmd_any_ok_o & zq_ok;
    cmd_rdwr_ok_o   = cmd_nodata_ok_o & dll_zero;
  end

endmodule

// File: rtl/sr_exit_gate_chk.sv
module sr_exit_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic sr_exit_i,
  input logic mrs_issued_i,
  input logic zqcl_issued_i,
  input logic cmd_any_ok_o,
  input logic cmd_nodata_ok_o,
  input logic cmd_rdwr_ok_o,
  input logic zqcl_req_o
);

  // R1: an MRS always closes the gate on the next cycle
  assert_mrs_closes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_issued_i |=> !cmd_any_ok_o);

  // R3: an exit closes every permit on the next cycle
  assert_exit_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit_i |=> (!cmd_any_ok_o && !cmd_nodata_ok_o && !cmd_rdwr_ok_o));

  // R6: request held until the calibration strobe
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (zqcl_req_o && !zqcl_issued_i && !sr_exit_i) |=> zqcl_req_o);

  // R6: request withdrawn once the strobe is taken
  assert_req_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (zqcl_req_o && zqcl_issued_i && !sr_exit_i) |=> !zqcl_req_o);

  // R7: non-data commands stay blocked while calibration is owed
  assert_req_blocks_nodata_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zqcl_req_o |-> !cmd_nodata_ok_o);

  // R9: a new exit withdraws a pending request
  assert_exit_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit_i |=> !zqcl_req_o);

endmodule

bind sr_exit_gate sr_exit_gate_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_q_n),
  .sr_exit_i       (sr_exit_i),
  .mrs_issued_i    (mrs_issued_i),
  .zqcl_issued_i   (zqcl_issued_i),
  .cmd_any_ok_o    (cmd_any_ok_o),
  .cmd_nodata_ok_o (cmd_nodata_ok_o),
  .cmd_rdwr_ok_o   (cmd_rdwr_ok_o),
  .zqcl_req_o      (zqcl_req_o)
);

// File: tb/sim_sr_exit_gate.sv
module sim_sr_exit_gate;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       sr_exit_i;
  logic       mrs_issued_i;
  logic       zqcl_issued_i;
  logic [9:0] cfg_trfc_i;
  logic [3:0] cfg_txs_ofs_i;
  logic [11:0] cfg_txsdll_i;
  logic [9:0] cfg_tzqoper_i;
  logic [3:0] cfg_tmod_i;
  logic       cmd_any_ok_o;
  logic       cmd_nodata_ok_o;
  logic       cmd_rdwr_ok_o;
  logic       zqcl_req_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  sr_exit_gate u0 (
    .clk             (clk),
    .rst_n           (rst_n),
    .sr_exit_i       (sr_exit_i),
    .mrs_issued_i    (mrs_issued_i),
    .zqcl_issued_i   (zqcl_issued_i),
    .cfg_trfc_i      (cfg_trfc_i),
    .cfg_txs_ofs_i   (cfg_txs_ofs_i),
    .cfg_txsdll_i    (cfg_txsdll_i),
    .cfg_tzqoper_i   (cfg_tzqoper_i),
    .cfg_tmod_i      (cfg_tmod_i),
    .cmd_any_ok_o    (cmd_any_ok_o),
    .cmd_nodata_ok_o (cmd_nodata_ok_o),
    .cmd_rdwr_ok_o   (cmd_rdwr_ok_o),
    .zqcl_req_o      (zqcl_req_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic set_cfg(input int trfc, input int ofs, input int dll,
                         input int zq, input int tmod);
    @(negedge clk);
    cfg_trfc_i    = 10'(trfc);
    cfg_txs_ofs_i = 4'(ofs);
    cfg_txsdll_i  = 12'(dll);
    cfg_tzqoper_i = 10'(zq);
    cfg_tmod_i    = 4'(tmod);
  endtask

  // Ends at the negedge right after the capturing edge (sample index 0)
  task automatic pulse_mrs();
    @(negedge clk) mrs_issued_i = 1'b1;
    @(negedge clk) mrs_issued_i = 1'b0;
  endtask

  task automatic pulse_exit();
    @(negedge clk) sr_exit_i = 1'b1;
    @(negedge clk) sr_exit_i = 1'b0;
  endtask

  task automatic measure_any_low(output int n);
    n = 0;
    while (!cmd_any_ok_o && n < 4000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // Runs one exit; answers the request on the cycle it appears.
  task automatic exit_seq(input bit early_zq, output int f_any, output int f_req,
                          output int f_nd, output int f_rw);
    f_any = -1; f_req = -1; f_nd = -1; f_rw = -1;
    pulse_exit();
    for (int idx = 0; idx < 3000; idx++) begin
      if (f_any < 0 && cmd_any_ok_o)    f_any = idx;
      if (f_req < 0 && zqcl_req_o)      f_req = idx;
      if (f_nd  < 0 && cmd_nodata_ok_o) f_nd  = idx;
      if (f_rw  < 0 && cmd_rdwr_ok_o)   f_rw  = idx;
      zqcl_issued_i = zqcl_req_o | (early_zq && idx == 0);
      if (f_nd >= 0 && f_rw >= 0) break;
      @(negedge clk);
    end
    zqcl_issued_i = 1'b0;
  endtask

  task automatic test_reset_state();
    chk_eq("R10 any after reset", int'(cmd_any_ok_o), 1);
    chk_eq("R10 nodata after reset", int'(cmd_nodata_ok_o), 1);
    chk_eq("R10 rdwr after reset", int'(cmd_rdwr_ok_o), 1);
    chk_eq("R10 req after reset", int'(zqcl_req_o), 0);
  endtask

  task automatic test_mrs(input int tmod);
    int n;
    set_cfg(20, 7, 300, 40, tmod);
    pulse_mrs();
    measure_any_low(n);
    chk_eq($sformatf("R1 R2 mrs window tmod=%0d", tmod), n, 8 + tmod);
  endtask

  task automatic test_mrs_retrigger();
    int n;
    set_cfg(20, 7, 300, 40, 6);
    pulse_mrs();
    repeat (3) @(negedge clk);
    chk_eq("R9 any low before retrigger", int'(cmd_any_ok_o), 0);
    pulse_mrs();
    measure_any_low(n);
    chk_eq("R9 mrs window after retrigger", n, 14);
  endtask

  task automatic test_exit(input string tag, input bit early_zq, input int trfc,
                           input int ofs, input int dll, input int zq,
                           input int exp_t, input int exp_d);
    int fa, fq, fn, fr, exp_nd, exp_rw;
    set_cfg(trfc, ofs, dll, zq, 0);
    exit_seq(early_zq, fa, fq, fn, fr);
    exp_nd = exp_t + 2 + zq;
    exp_rw = (exp_nd > exp_d) ? exp_nd : exp_d;
    chk_eq({"R3 R4 any window ", tag}, fa, exp_t);
    chk_eq({"R6 request cycle ", tag}, fq, exp_t + 1);
    chk_eq({"R7 nodata release ", tag}, fn, exp_nd);
    chk_eq({"R5 R8 rdwr release ", tag}, fr, exp_rw);
    repeat (2) @(negedge clk);
    chk_eq({"R6 request cleared ", tag}, int'(zqcl_req_o), 0);
  endtask

  task automatic test_exit_retrigger();
    int fa, fq, fn, fr;
    set_cfg(20, 7, 300, 40, 0);
    pulse_exit();
    repeat (10) @(negedge clk);
    exit_seq(1'b0, fa, fq, fn, fr);
    chk_eq("R9 exit retrigger any", fa, 27);
    chk_eq("R9 exit retrigger req", fq, 28);
    chk_eq("R9 exit retrigger nodata", fn, 69);
    chk_eq("R9 exit retrigger rdwr", fr, 300);
    // exit while calibration is pending drops the request
    set_cfg(4, 3, 128, 50, 0);
    pulse_exit();
    repeat (10) @(negedge clk);
    chk_eq("R9 request pending", int'(zqcl_req_o), 1);
    pulse_exit();
    chk_eq("R9 request withdrawn", int'(zqcl_req_o), 0);
    chk_eq("R9 any closed again", int'(cmd_any_ok_o), 0);
    repeat (200) @(negedge clk);
    zqcl_issued_i = 1'b1;
    @(negedge clk) zqcl_issued_i = 1'b0;
    repeat (60) @(negedge clk);
  endtask

  task automatic test_mid_reset();
    set_cfg(20, 7, 300, 40, 0);
    pulse_exit();
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    test_reset_state();
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset_state();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    rst_n = 1'b0;
    sr_exit_i = 1'b0;
    mrs_issued_i = 1'b0;
    zqcl_issued_i = 1'b0;
    cfg_trfc_i = 10'd20;
    cfg_txs_ofs_i = 4'd7;
    cfg_txsdll_i = 12'd300;
    cfg_tzqoper_i = 10'd40;
    cfg_tmod_i = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    test_reset_state();
    test_mrs(0);
    test_mrs(4);
    test_mrs(15);
    test_mrs_retrigger();
    test_exit("basic", 1'b0, 20, 7, 300, 40, 27, 300);
    test_exit("low clamp", 1'b0, 10, 0, 5, 5, 13, 128);
    test_exit("high clamp", 1'b0, 50, 15, 2000, 0, 61, 1024);
    test_exit("long calibration", 1'b0, 200, 11, 128, 300, 211, 128);
    test_exit("early strobe ignored", 1'b1, 20, 7, 300, 40, 27, 300);
    test_exit_retrigger();
    test_mid_reset();

    summary();
  end

endmodule